// File: doc/BRIEF.md
# FR-FCFS Request Selector

This block chooses which pending DRAM request a memory controller should issue next. The requests sit in an age-ordered queue. Each slot has a valid bit, an age rank where 0 is the oldest, a rank, a bank, a row and a flat bank index. For every bank the selector also receives the row that is currently open and the cycle at which the bank becomes free. A companion block supplies a one-hot-or-more mask marking the banks that will become free soonest among those with queued work.

In first-ready mode the selector looks for requests to an already-open row and takes the oldest of them. When there is no such request, it does not simply fall back to the oldest request. It takes the oldest request whose bank is free now, or whose bank is flagged in the soonest-free mask. If nothing qualifies, the oldest request wins, so a non-empty queue always yields a choice. A mode input forces strict oldest-first order.

The choice is evaluated across all slots in one cycle and registered. The controller sees the index and a valid flag one clock after the inputs it was computed from.

Top module: `frfcfs_pick`

## Requirements
- R1: With `fcfs_only` high, the selected slot is the valid slot with the smallest age value, whatever the row or bank state.
- R2: With `fcfs_only` low, a valid slot is a row hit when its row equals the open row of its bank, and the oldest row hit is selected even when older non-hit slots exist.
- R3: With `fcfs_only` low and no row hit, the oldest valid slot whose bank free cycle is less than or equal to `now` is selected (equality qualifies).
- R4: With `fcfs_only` low and no row hit, a slot whose flat bank index has its bit set in `early_mask` also qualifies under R3, even if its bank is not free yet.
- R5: The flat bank index of a slot equals rank × BANKS_PER_RANK + bank (rank 1, bank 0 is index 8 by default). Per-bank open row, free cycle and mask bit are all looked up by this index.
- R6: When a row hit exists, bank readiness and `early_mask` have no effect on the choice.
- R7: With `fcfs_only` low and no slot a row hit, ready or masked, the oldest valid slot is selected.
- R8: `pick_vld` is low exactly when the sampled queue holds no valid slot.
- R9: The outputs are registered: a choice appears on the clock edge after its inputs are presented, and reset drives `pick_vld` and `pick_idx` to 0.
- R10: A slot whose valid bit is low is never selected, even when its row would hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcfs_only | input | 1 | 1 = strict oldest-first, 0 = first-ready policy |
| now | input | TIME_W | Current cycle count |
| ent_vld | input | DEPTH | Per-slot valid bits |
| ent_age | input | DEPTH*AGE_W | Per-slot age rank, 0 = oldest |
| ent_rank | input | DEPTH*RANK_W | Per-slot rank |
| ent_bank | input | DEPTH*BANK_W | Per-slot bank within rank |
| ent_row | input | DEPTH*ROW_W | Per-slot target row |
| ent_bid | input | DEPTH*BID_W | Per-slot flat bank index |
| bank_open_row | input | NBANK*ROW_W | Open row of each bank, by flat index |
| bank_free_at | input | NBANK*TIME_W | Free cycle of each bank, by flat index |
| early_mask | input | NBANK | Banks among the soonest to become free |
| pick_vld | output | 1 | A slot has been selected |
| pick_idx | output | IDX_W | Index of the selected slot |

## Verification
The hardest case to reach is the one where the flat bank index matters: a slot in rank 1 whose row matches the open row of its flat-indexed bank but not that of the same bank number in rank 0. The same holds for the mask, where only bit 8 is set for a rank-1 bank-0 request. The stimulus deliberately gives the two candidate banks different open rows and masks a single high bit, so a lookup that drops the rank lands on the wrong bank and visibly changes the chosen slot. The boundary where the free cycle equals `now` is driven directly and then moved one cycle later, so the choice shifts to a different slot.

// File: rtl/frfcfs_pick.sv
`timescale 1ns/1ps
module frfcfs_pick #(
  parameter int DEPTH          = 16,
  parameter int RANKS          = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int ROW_W          = 14,
  parameter int TIME_W         = 32,
  localparam int NBANK  = RANKS * BANKS_PER_RANK,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AGE_W  = IDX_W,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
  localparam int BID_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fcfs_only,
  input  logic [TIME_W-1:0]       now,
  input  logic [DEPTH-1:0]        ent_vld,
  input  logic [DEPTH*AGE_W-1:0]  ent_age,
  input  logic [DEPTH*RANK_W-1:0] ent_rank,
  input  logic [DEPTH*BANK_W-1:0] ent_bank,
  input  logic [DEPTH*ROW_W-1:0]  ent_row,
  input  logic [DEPTH*BID_W-1:0]  ent_bid,
  input  logic [NBANK*ROW_W-1:0]  bank_open_row,
  input  logic [NBANK*TIME_W-1:0] bank_free_at,
  input  logic [NBANK-1:0]        early_mask,
  output logic                    pick_vld,
  output logic [IDX_W-1:0]        pick_idx
);

  function automatic logic [IDX_W-1:0] oldest(input logic [DEPTH-1:0] cand,
                                              input logic [DEPTH*AGE_W-1:0] ages);
    logic [IDX_W-1:0] best;
    logic [AGE_W-1:0] best_age;
    logic             seen;
    best = '0;
    best_age = '1;
    seen = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!seen || ages[i*AGE_W +: AGE_W] < best_age)) begin
        best     = IDX_W'(i);
        best_age = ages[i*AGE_W +: AGE_W];
        seen     = 1'b1;
      end
    end
    return best;
  endfunction

  function automatic logic [AGE_W-1:0] age_at(input logic [DEPTH*AGE_W-1:0] v,
                                              input logic [IDX_W-1:0] i);
    return v[i*AGE_W +: AGE_W];
  endfunction

  function automatic logic bit_at(input logic [DEPTH-1:0] v, input logic [IDX_W-1:0] i);
    return v[i];
  endfunction

  logic [DEPTH-1:0] hit_v, rdy_v;
  logic [IDX_W-1:0] head_idx, hit_idx, rdy_idx, next_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [BID_W-1:0] bid;
    assign bid = ent_bid[g*BID_W +: BID_W];
    assign hit_v[g] = ent_vld[g] &&
                      (bank_open_row[bid*ROW_W +: ROW_W] == ent_row[g*ROW_W +: ROW_W]);
    assign rdy_v[g] = ent_vld[g] &&
                      ((bank_free_at[bid*TIME_W +: TIME_W] <= now) || early_mask[bid]);

    AST_FLAT_BANK_ID: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld[g] |-> (int'(ent_bid[g*BID_W +: BID_W]) ==
                      int'(ent_rank[g*RANK_W +: RANK_W]) * BANKS_PER_RANK +
                      int'(ent_bank[g*BANK_W +: BANK_W]))); // R5

    AST_FCFS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      fcfs_only && ent_vld[g] |=>
        pick_vld && age_at($past(ent_age), pick_idx) <= $past(ent_age[g*AGE_W +: AGE_W])); // R1

    AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !fcfs_only && hit_v[g] |=>
        bit_at($past(hit_v), pick_idx) &&
        age_at($past(ent_age), pick_idx) <= $past(ent_age[g*AGE_W +: AGE_W])); // R2

    AST_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !fcfs_only && !(|hit_v) && rdy_v[g] |=>
        bit_at($past(rdy_v), pick_idx) &&
        age_at($past(ent_age), pick_idx) <= $past(ent_age[g*AGE_W +: AGE_W])); // R3

    AST_FALLBACK_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      !fcfs_only && !(|hit_v) && !(|rdy_v) && ent_vld[g] |=>
        age_at($past(ent_age), pick_idx) <= $past(ent_age[g*AGE_W +: AGE_W])); // R7
  end

  assign head_idx = oldest(ent_vld, ent_age);
  assign hit_idx  = oldest(hit_v, ent_age);
  assign rdy_idx  = oldest(rdy_v, ent_age);

  always_comb begin
    if (fcfs_only)   next_idx = head_idx;
    else if (|hit_v) next_idx = hit_idx;
    else if (|rdy_v) next_idx = rdy_idx;
    else             next_idx = head_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_vld <= 1'b0;
      pick_idx <= '0;
    end else begin
      pick_vld <= |ent_vld;
      pick_idx <= (|ent_vld) ? next_idx : '0;
    end
  end

  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ent_vld) |=> !pick_vld); // R8
  AST_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|ent_vld) |=> pick_vld); // R8
  AST_PICK_VALID_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> bit_at($past(ent_vld), pick_idx)); // R10

endmodule

// File: tb/frfcfs_pick_tb.sv
`timescale 1ns/1ps
module frfcfs_pick_tb;
  localparam int DEPTH = 16;
  localparam int NBANK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        fcfs_only;
  logic [31:0] now;
  logic [DEPTH-1:0] vld_a;
  logic [3:0]  age_a [DEPTH];
  logic        rk_a  [DEPTH];
  logic [2:0]  bk_a  [DEPTH];
  logic [13:0] row_a [DEPTH];
  logic [3:0]  bid_a [DEPTH];
  logic [13:0] orow  [NBANK];
  logic [31:0] free  [NBANK];
  logic [NBANK-1:0] mask;

  logic [DEPTH*4-1:0]  ent_age;
  logic [DEPTH-1:0]    ent_rank;
  logic [DEPTH*3-1:0]  ent_bank;
  logic [DEPTH*14-1:0] ent_row;
  logic [DEPTH*4-1:0]  ent_bid;
  logic [NBANK*14-1:0] bank_open_row;
  logic [NBANK*32-1:0] bank_free_at;
  logic        pick_vld;
  logic [3:0]  pick_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_age[i*4 +: 4]   = age_a[i];
      ent_rank[i]         = rk_a[i];
      ent_bank[i*3 +: 3]  = bk_a[i];
      ent_row[i*14 +: 14] = row_a[i];
      ent_bid[i*4 +: 4]   = bid_a[i];
    end
    for (int b = 0; b < NBANK; b++) begin
      bank_open_row[b*14 +: 14] = orow[b];
      bank_free_at[b*32 +: 32]  = free[b];
    end
  end

  frfcfs_pick u_dut (
    .clk(clk), .rst_n(rst_n), .fcfs_only(fcfs_only), .now(now),
    .ent_vld(vld_a), .ent_age(ent_age), .ent_rank(ent_rank), .ent_bank(ent_bank),
    .ent_row(ent_row), .ent_bid(ent_bid), .bank_open_row(bank_open_row),
    .bank_free_at(bank_free_at), .early_mask(mask),
    .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic exp_vld, input logic [3:0] exp_idx);
    n_run++;
    if (pick_vld !== exp_vld || (exp_vld && pick_idx !== exp_idx)) begin
      n_fail++;
      $display("FAIL %s: actual vld=%0b idx=%0d, expected vld=%0b idx=%0d",
               req, pick_vld, pick_idx, exp_vld, exp_idx);
    end
  endtask

  task automatic clear();
    fcfs_only = 1'b0;
    now = 32'd10;
    mask = '0;
    vld_a = '0;
    for (int i = 0; i < DEPTH; i++) begin
      age_a[i] = 4'(i); rk_a[i] = 1'b0; bk_a[i] = '0;
      row_a[i] = 14'h3000 + 14'(i); bid_a[i] = '0;
    end
    for (int b = 0; b < NBANK; b++) begin
      orow[b] = 14'(100 + b);
      free[b] = 32'd1000;
    end
  endtask

  task automatic set_ent(input int i, input int a, input int r, input int b, input int rw);
    vld_a[i] = 1'b1;
    age_a[i] = 4'(a);
    rk_a[i]  = r[0];
    bk_a[i]  = 3'(b);
    row_a[i] = 14'(rw);
    bid_a[i] = 4'(r * 8 + b);
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clear();
    set_ent(3, 0, 0, 1, 5);
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", 1'b0, 4'd0);
    n_run++;
    if (pick_idx !== 4'd0) begin
      n_fail++;
      $display("FAIL R9 reset idx: actual %0d expected 0", pick_idx);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_empty();
    @(negedge clk); clear();
    settle();
    check("R8 empty queue", 1'b0, 4'd0);
  endtask

  task automatic t_fcfs();
    @(negedge clk); clear();
    set_ent(3, 2, 0, 1, 101);
    set_ent(7, 0, 0, 4, 5);
    set_ent(5, 1, 0, 6, 7);
    fcfs_only = 1'b1;
    settle();
    check("R1 fcfs ignores row hit", 1'b1, 4'd7);
  endtask

  task automatic t_hit();
    @(negedge clk); clear();
    set_ent(3, 2, 0, 1, 101);
    set_ent(7, 0, 0, 4, 5);
    set_ent(5, 1, 0, 6, 7);
    set_ent(9, 3, 1, 1, 109);
    settle();
    check("R2 oldest row hit", 1'b1, 4'd3);
  endtask

  task automatic t_hit_beats_ready();
    @(negedge clk); clear();
    set_ent(4, 3, 0, 2, 102);
    set_ent(2, 0, 0, 5, 50);
    mask[5] = 1'b1;
    free[5] = 32'd0;
    settle();
    check("R6 mask and readiness ignored on hit", 1'b1, 4'd4);
  endtask

  task automatic t_ready();
    @(negedge clk); clear();
    set_ent(1, 0, 0, 2, 1);
    set_ent(6, 1, 0, 5, 1);
    set_ent(8, 2, 0, 6, 1);
    free[5] = 32'd10;
    free[6] = 32'd0;
    settle();
    check("R3 free cycle equal to now", 1'b1, 4'd6);
    @(negedge clk);
    free[5] = 32'd11;
    settle();
    check("R3 free cycle one past now", 1'b1, 4'd8);
  endtask

  task automatic t_mask();
    @(negedge clk); clear();
    set_ent(0, 0, 0, 3, 1);
    set_ent(10, 1, 1, 0, 1);
    mask = 16'h0100;
    settle();
    check("R4 R5 mask bit 8 for rank1 bank0", 1'b1, 4'd10);
  endtask

  task automatic t_flat_hit();
    @(negedge clk); clear();
    set_ent(0, 0, 0, 4, 1);
    set_ent(11, 1, 1, 2, 110);
    settle();
    check("R5 open row looked up by flat index", 1'b1, 4'd11);
  endtask

  task automatic t_fallback();
    @(negedge clk); clear();
    set_ent(2, 1, 0, 1, 1);
    set_ent(11, 0, 1, 3, 1);
    settle();
    check("R7 fallback to head", 1'b1, 4'd11);
  endtask

  task automatic t_invalid();
    @(negedge clk); clear();
    age_a[5] = 4'd0; bk_a[5] = 3'd0; row_a[5] = 14'd100;
    set_ent(12, 1, 0, 3, 1);
    set_ent(13, 2, 0, 4, 1);
    free[4] = 32'd0;
    settle();
    check("R10 invalid hit slot skipped", 1'b1, 4'd13);
  endtask

  task automatic t_latency();
    @(negedge clk); clear();
    set_ent(14, 0, 0, 1, 1);
    settle();
    check("R9 first choice", 1'b1, 4'd14);
    @(negedge clk); clear();
    set_ent(15, 0, 0, 1, 1);
    #1;
    check("R9 holds until next edge", 1'b1, 4'd14);
    settle();
    check("R9 updates on next edge", 1'b1, 4'd15);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_empty();
    t_fcfs();
    t_hit();
    t_hit_beats_ready();
    t_ready();
    t_mask();
    t_flat_hit();
    t_fallback();
    t_invalid();
    t_latency();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule